// File: doc/BRIEF.md
# ADC Result DMA Address Generator

This block sits between a multi-channel sampling converter and a DMA engine. For every accepted conversion result it issues a word address, with a one-cycle strobe, at which the DMA engine stores that result. At the end of each programmed group of sample/conversion sequences it raises a one-cycle DMA request and sets a sticky interrupt flag.

Two buffer layouts are available. In ordered layout, results are placed back to back in the order they were converted, exactly as a plain result buffer would hold them. In scatter layout, every analog input owns a private region of a programmable power-of-two size. Within that region a shared buffer pointer selects the word, and the pointer steps forward once per group of sequences.

The converter runs either in a four-sample/hold mode, which gives up to four results per sequence, or in a single sample/hold mode, which gives one result per sequence. Software may change that mode only while the block is disabled.

Top module: `adc_dma_addr_gen`

## Requirements
- R1: With `order_mode`=1 (ordered layout), the address of an accepted result is the number of results accepted since the last group end or since enable. The count restarts at 0 after every group end.
- R2: With `order_mode`=0 (scatter layout), the address is `res_ch` × 2^`buf_size_log2` + buffer pointer, where `buf_size_log2` is in 0..7 (region size 1..128 words).
- R3: A group is `seq_per_inc`+1 sequences. The `seq_end` pulse that completes a group makes `dma_req` high for exactly the next cycle, and no other `seq_end` does so.
- R4: The buffer pointer starts at 0 and steps by one at each group end. It wraps to 0 when it reaches the region size.
- R5: In mode 0 (four sample/holds) at most 4 results are accepted per sequence. In mode 1 (single sample/hold) at most 1 is accepted. Results beyond the limit produce no `dma_addr_valid`. The per-sequence count restarts after the cycle in which `seq_end` is high, and a result arriving in that same cycle still counts toward the ending sequence.
- R6: A pulse on `mode_wr` loads `mode_wdata` into the mode only while `enable` is 0. A pulse while `enable` is 1 is ignored.
- R7: While `enable` is 0, results and sequence ends are ignored, and the buffer pointer, the group count, the ordered-layout count and any pending request are cleared.
- R8: `irq_flag` is set at each group end and stays set until `irq_clr` is pulsed. If a group end and `irq_clr` fall in the same cycle, the flag is set.
- R9: `dma_addr` and `dma_addr_valid` appear in the cycle after the accepted result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Module on; low clears sequencing state |
| order_mode | input | 1 | 1 = ordered layout, 0 = scatter layout |
| seq_per_inc | input | 4 | Sequences per group minus one |
| buf_size_log2 | input | 3 | Log2 of per-channel region size in words |
| mode_wr | input | 1 | Strobe to write the sample/hold mode |
| mode_wdata | input | 1 | 0 = four sample/holds, 1 = single sample/hold |
| res_valid | input | 1 | Conversion result available this cycle |
| res_ch | input | 5 | Analog input index of the result, 0..31 |
| seq_end | input | 1 | Current sample/conversion sequence ends this cycle |
| irq_clr | input | 1 | Write-1-to-clear for the interrupt flag |
| dma_addr | output | 12 | Word address for the last accepted result |
| dma_addr_valid | output | 1 | One-cycle strobe qualifying `dma_addr` |
| dma_req | output | 1 | One-cycle DMA request at group end |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with its default parameters: a limit of four results per sequence in the four-sample/hold mode and a 6-bit ordered-layout counter. It programs a 4-word region and a 2-sequence group, so a pointer wrap, an over-limit fifth result and results that coincide with sequence ends all occur within about twenty cycles. Channel 31 with the pointer non-zero reaches the upper part of the address range. A 16-sequence group exercises the widest value of the 4-bit count.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;

    localparam int CH_W        = 5;
    localparam int SIZE_LOG2_W = 3;
    localparam int PTR_W       = 7;
    localparam int ADDR_W      = CH_W + PTR_W;
    localparam int SEQ_CNT_W   = 4;

    typedef enum logic {
        LAYOUT_SCATTER = 1'b0,
        LAYOUT_ORDERED = 1'b1
    } layout_e;

    typedef enum logic {
        RES_10B_QUAD   = 1'b0,
        RES_12B_SINGLE = 1'b1
    } res_mode_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } addr_beat_t;

    // Mask of a power-of-two region: 2^lg - 1
    function automatic logic [PTR_W-1:0] size_mask(input logic [SIZE_LOG2_W-1:0] lg);
        logic [PTR_W:0] m;
        m = ({{PTR_W{1'b0}}, 1'b1} << lg) - 1'b1;
        return m[PTR_W-1:0];
    endfunction

    // Channel region base plus pointer inside the region
    function automatic logic [ADDR_W-1:0] scatter_addr(
        input logic [CH_W-1:0]        ch,
        input logic [PTR_W-1:0]       ptr,
        input logic [SIZE_LOG2_W-1:0] lg
    );
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] off;
        base = {{PTR_W{1'b0}}, ch} << lg;
        off  = {{CH_W{1'b0}}, ptr & size_mask(lg)};
        return base + off;
    endfunction

endpackage

// File: rtl/adc_dma_seq_ctrl.sv
module adc_dma_seq_ctrl
    import adc_dma_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable,
    input  logic                   seq_end,
    input  logic                   irq_clr,
    input  logic [SEQ_CNT_W-1:0]   seq_per_inc,
    input  logic [SIZE_LOG2_W-1:0] size_log2,
    output logic [PTR_W-1:0]       buf_ptr,
    output logic                   interval_end,
    output logic                   dma_req,
    output logic                   irq_flag
);

    logic [SEQ_CNT_W-1:0] seq_cnt;

    assign interval_end = enable && seq_end && (seq_cnt >= seq_per_inc);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            seq_cnt <= '0;
            buf_ptr <= '0;
            dma_req <= 1'b0;
        end else begin
            dma_req <= interval_end;
            if (seq_end) begin
                if (interval_end) begin
                    seq_cnt <= '0;
                    buf_ptr <= (buf_ptr + 1'b1) & size_mask(size_log2);
                end else begin
                    seq_cnt <= seq_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag <= 1'b0;
        end else if (interval_end) begin
            irq_flag <= 1'b1;
        end else if (irq_clr) begin
            irq_flag <= 1'b0;
        end
    end

    // R3
    req_after_seq_end_chk: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> $past(seq_end && enable));

    // R4
    ptr_moves_on_group_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_ptr != $past(buf_ptr)) |-> (dma_req || !$past(enable)));

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R8
    irq_rise_with_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> dma_req);

    // R7
    idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !dma_req);

endmodule

// File: rtl/adc_dma_addr_calc.sv
module adc_dma_addr_calc
    import adc_dma_pkg::*;
#(
    parameter int MAX_RES_10B = 4,
    parameter int SLOT_W      = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable,
    input  layout_e                layout,
    input  res_mode_e              res_mode,
    input  logic [SIZE_LOG2_W-1:0] size_log2,
    input  logic                   res_valid,
    input  logic [CH_W-1:0]        res_ch,
    input  logic                   seq_end,
    input  logic                   interval_end,
    input  logic [PTR_W-1:0]       buf_ptr,
    output addr_beat_t             beat
);

    localparam int CNT_W = $clog2(MAX_RES_10B + 1);

    logic [CNT_W-1:0]  res_cnt;
    logic [CNT_W-1:0]  limit;
    logic [SLOT_W-1:0] slot;
    logic              accept;
    logic [ADDR_W-1:0] next_addr;

    assign limit  = (res_mode == RES_12B_SINGLE) ? CNT_W'(1) : CNT_W'(MAX_RES_10B);
    assign accept = enable && res_valid && (res_cnt < limit);

    generate
        if (SLOT_W >= ADDR_W) begin : g_slot_wide
            assign next_addr = (layout == LAYOUT_ORDERED) ? slot[ADDR_W-1:0]
                                                          : scatter_addr(res_ch, buf_ptr, size_log2);
        end else begin : g_slot_narrow
            assign next_addr = (layout == LAYOUT_ORDERED) ? {{(ADDR_W-SLOT_W){1'b0}}, slot}
                                                          : scatter_addr(res_ch, buf_ptr, size_log2);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            res_cnt    <= '0;
            slot       <= '0;
            beat.valid <= 1'b0;
            if (rst) beat.addr <= '0;
        end else begin
            beat.valid <= accept;
            if (accept) beat.addr <= next_addr;
            res_cnt <= seq_end ? '0 : res_cnt + CNT_W'(accept);
            slot    <= interval_end ? '0 : slot + SLOT_W'(accept);
        end
    end

    // R9
    valid_follows_result_chk: assert property (@(posedge clk) disable iff (rst)
        beat.valid |-> $past(res_valid && enable));

    // R5
    single_per_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (beat.valid && $past(beat.valid) && res_mode == RES_12B_SINGLE
         && $past(res_mode) == RES_12B_SINGLE && $past(enable, 2))
        |-> $past(seq_end, 2));

endmodule

// File: rtl/adc_dma_addr_gen.sv
module adc_dma_addr_gen
    import adc_dma_pkg::*;
#(
    parameter int MAX_RES_10B = 4,
    parameter int SLOT_W      = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable,
    input  logic                   order_mode,
    input  logic [SEQ_CNT_W-1:0]   seq_per_inc,
    input  logic [SIZE_LOG2_W-1:0] buf_size_log2,
    input  logic                   mode_wr,
    input  logic                   mode_wdata,
    input  logic                   res_valid,
    input  logic [CH_W-1:0]        res_ch,
    input  logic                   seq_end,
    input  logic                   irq_clr,
    output logic [ADDR_W-1:0]      dma_addr,
    output logic                   dma_addr_valid,
    output logic                   dma_req,
    output logic                   irq_flag
);

    res_mode_e        mode_q;
    logic [PTR_W-1:0] buf_ptr;
    logic             interval_end;
    addr_beat_t       beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RES_10B_QUAD;
        end else if (mode_wr && !enable) begin
            mode_q <= res_mode_e'(mode_wdata);
        end
    end

    // R6
    mode_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && mode_wr) |=> $stable(mode_q));

    adc_dma_seq_ctrl i_seq (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .seq_end      (seq_end),
        .irq_clr      (irq_clr),
        .seq_per_inc  (seq_per_inc),
        .size_log2    (buf_size_log2),
        .buf_ptr      (buf_ptr),
        .interval_end (interval_end),
        .dma_req      (dma_req),
        .irq_flag     (irq_flag)
    );

    adc_dma_addr_calc #(
        .MAX_RES_10B (MAX_RES_10B),
        .SLOT_W      (SLOT_W)
    ) i_calc (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .layout       (layout_e'(order_mode)),
        .res_mode     (mode_q),
        .size_log2    (buf_size_log2),
        .res_valid    (res_valid),
        .res_ch       (res_ch),
        .seq_end      (seq_end),
        .interval_end (interval_end),
        .buf_ptr      (buf_ptr),
        .beat         (beat)
    );

    assign dma_addr       = beat.addr;
    assign dma_addr_valid = beat.valid;

    // R7
    no_addr_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !dma_addr_valid);

endmodule

// File: tb/test_adc_dma_addr_gen.sv
module test_adc_dma_addr_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        order_mode = 1'b0;
    logic [3:0]  seq_per_inc = 4'd1;
    logic [2:0]  buf_size_log2 = 3'd2;
    logic        mode_wr = 1'b0;
    logic        mode_wdata = 1'b0;
    logic        res_valid = 1'b0;
    logic [4:0]  res_ch = 5'd0;
    logic        seq_end = 1'b0;
    logic        irq_clr = 1'b0;
    logic [11:0] dma_addr;
    logic        dma_addr_valid;
    logic        dma_req;
    logic        irq_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    adc_dma_addr_gen i_adc_dma_addr_gen (
        .clk            (clk),
        .rst            (rst),
        .enable         (enable),
        .order_mode     (order_mode),
        .seq_per_inc    (seq_per_inc),
        .buf_size_log2  (buf_size_log2),
        .mode_wr        (mode_wr),
        .mode_wdata     (mode_wdata),
        .res_valid      (res_valid),
        .res_ch         (res_ch),
        .seq_end        (seq_end),
        .irq_clr        (irq_clr),
        .dma_addr       (dma_addr),
        .dma_addr_valid (dma_addr_valid),
        .dma_req        (dma_req),
        .irq_flag       (irq_flag)
    );

    // res, ch[4:0], eos, exp_valid, exp_addr[11:0], exp_req
    // scatter layout, 4-word regions, group of 2 sequences, four sample/holds
    localparam logic [20:0] VEC [0:18] = '{
        {1'b1, 5'd3,  1'b0, 1'b1, 12'd12,  1'b0},
        {1'b1, 5'd7,  1'b0, 1'b1, 12'd28,  1'b0},
        {1'b0, 5'd0,  1'b1, 1'b0, 12'd0,   1'b0},
        {1'b1, 5'd1,  1'b0, 1'b1, 12'd4,   1'b0},
        {1'b0, 5'd0,  1'b1, 1'b0, 12'd0,   1'b1},
        {1'b1, 5'd1,  1'b0, 1'b1, 12'd5,   1'b0},
        {1'b1, 5'd0,  1'b1, 1'b1, 12'd1,   1'b0},
        {1'b1, 5'd31, 1'b1, 1'b1, 12'd125, 1'b1},
        {1'b1, 5'd2,  1'b0, 1'b1, 12'd10,  1'b0},
        {1'b1, 5'd0,  1'b0, 1'b1, 12'd2,   1'b0},
        {1'b1, 5'd0,  1'b0, 1'b1, 12'd2,   1'b0},
        {1'b1, 5'd0,  1'b0, 1'b1, 12'd2,   1'b0},
        {1'b1, 5'd5,  1'b0, 1'b0, 12'd0,   1'b0},
        {1'b0, 5'd0,  1'b1, 1'b0, 12'd0,   1'b0},
        {1'b0, 5'd0,  1'b1, 1'b0, 12'd0,   1'b1},
        {1'b1, 5'd0,  1'b0, 1'b1, 12'd3,   1'b0},
        {1'b0, 5'd0,  1'b1, 1'b0, 12'd0,   1'b0},
        {1'b0, 5'd0,  1'b1, 1'b0, 12'd0,   1'b1},
        {1'b1, 5'd0,  1'b0, 1'b1, 12'd0,   1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive for one cycle (called at a falling edge), return at the next falling edge
    task automatic step(input logic rv, input logic [4:0] ch, input logic eos);
        res_valid = rv;
        res_ch    = ch;
        seq_end   = eos;
        @(negedge clk);
        res_valid = 1'b0;
        seq_end   = 1'b0;
        mode_wr   = 1'b0;
        irq_clr   = 1'b0;
    endtask

    task automatic expect_addr(input string req, input int exp);
        chk(dma_addr_valid === 1'b1, req, int'(dma_addr_valid), 1);
        chk(dma_addr === 12'(exp), req, int'(dma_addr), exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(dma_addr_valid === 1'b0, "R7 reset valid", int'(dma_addr_valid), 0);
        chk(dma_req === 1'b0, "R3 reset req", int'(dma_req), 0);
        chk(irq_flag === 1'b0, "R8 reset irq", int'(irq_flag), 0);

        enable = 1'b1;
        // table: R2 scatter addresses, R3 groups, R4 wrap, R5 limit, R9 latency
        for (int i = 0; i < 19; i++) begin
            step(VEC[i][20], VEC[i][19:15], VEC[i][14]);
            chk(dma_addr_valid === VEC[i][13], "R5/R9 valid", int'(dma_addr_valid), int'(VEC[i][13]));
            if (VEC[i][13])
                chk(dma_addr === VEC[i][12:1], "R2/R4 addr", int'(dma_addr), int'(VEC[i][12:1]));
            chk(dma_req === VEC[i][0], "R3 req", int'(dma_req), int'(VEC[i][0]));
        end

        // R8: flag still set, clear, stays clear
        chk(irq_flag === 1'b1, "R8 sticky", int'(irq_flag), 1);
        irq_clr = 1'b1;
        step(1'b0, 5'd0, 1'b0);
        chk(irq_flag === 1'b0, "R8 clear", int'(irq_flag), 0);
        step(1'b0, 5'd0, 1'b0);
        chk(irq_flag === 1'b0, "R8 stays clear", int'(irq_flag), 0);
        // R8: group end and clear in the same cycle -> set wins
        step(1'b0, 5'd0, 1'b1);
        irq_clr = 1'b1;
        step(1'b0, 5'd0, 1'b1);
        chk(irq_flag === 1'b1, "R8 set wins", int'(irq_flag), 1);
        irq_clr = 1'b1;
        step(1'b0, 5'd0, 1'b0);

        // R7: pointer now 1; disable clears it and ignores activity
        enable = 1'b0;
        step(1'b1, 5'd1, 1'b1);
        chk(dma_addr_valid === 1'b0, "R7 result ignored", int'(dma_addr_valid), 0);
        chk(dma_req === 1'b0, "R7 req ignored", int'(dma_req), 0);
        enable = 1'b1;
        step(1'b1, 5'd1, 1'b0);
        expect_addr("R7 pointer cleared", 4);
        step(1'b0, 5'd0, 1'b1);
        chk(dma_req === 1'b0, "R7 group count cleared", int'(dma_req), 0);

        // R6: write while enabled ignored (still four results per sequence)
        seq_per_inc = 4'd0;
        enable = 1'b0;
        step(1'b0, 5'd0, 1'b0);
        enable = 1'b1;
        mode_wr = 1'b1;
        mode_wdata = 1'b1;
        step(1'b0, 5'd0, 1'b0);
        step(1'b1, 5'd2, 1'b0);
        expect_addr("R6 first", 8);
        step(1'b1, 5'd3, 1'b1);
        expect_addr("R6 write ignored", 12);
        // R5/R6: write while disabled -> single sample/hold
        enable = 1'b0;
        mode_wr = 1'b1;
        mode_wdata = 1'b1;
        step(1'b0, 5'd0, 1'b0);
        enable = 1'b1;
        step(1'b1, 5'd2, 1'b0);
        expect_addr("R5 single first", 8);
        step(1'b1, 5'd3, 1'b0);
        chk(dma_addr_valid === 1'b0, "R5 single second dropped", int'(dma_addr_valid), 0);
        step(1'b0, 5'd0, 1'b1);
        chk(dma_req === 1'b1, "R3 one-sequence group", int'(dma_req), 1);

        // R1: ordered layout, back to four sample/holds, group of 2
        enable = 1'b0;
        mode_wr = 1'b1;
        mode_wdata = 1'b0;
        order_mode = 1'b1;
        seq_per_inc = 4'd1;
        step(1'b0, 5'd0, 1'b0);
        enable = 1'b1;
        step(1'b1, 5'd9, 1'b0);
        expect_addr("R1 slot 0", 0);
        step(1'b1, 5'd4, 1'b0);
        expect_addr("R1 slot 1", 1);
        step(1'b0, 5'd0, 1'b1);
        chk(dma_req === 1'b0, "R3 mid group", int'(dma_req), 0);
        step(1'b1, 5'd9, 1'b1);
        expect_addr("R1 slot 2", 2);
        chk(dma_req === 1'b1, "R3 group end", int'(dma_req), 1);
        step(1'b1, 5'd2, 1'b0);
        expect_addr("R1 restart", 0);

        // R3: widest group, 16 sequences
        enable = 1'b0;
        seq_per_inc = 4'd15;
        step(1'b0, 5'd0, 1'b0);
        enable = 1'b1;
        for (int k = 0; k < 15; k++) begin
            step(1'b0, 5'd0, 1'b1);
            chk(dma_req === 1'b0, "R3 16-group early", int'(dma_req), 0);
        end
        step(1'b0, 5'd0, 1'b1);
        chk(dma_req === 1'b1, "R3 16-group end", int'(dma_req), 1);
        step(1'b0, 5'd0, 1'b0);
        chk(dma_req === 1'b0, "R3 single-cycle pulse", int'(dma_req), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule